// File: doc/BRIEF.md
# SPI Status Flag Controller

This block keeps the three status flags of a serial peripheral interface unit. These are received-byte-ready, write-collision and mode-fault. It also runs the sequences that set and clear them. The shift engine gives it a one-cycle strobe when a byte completes and a level that is high while a transfer is running. The slave-select pin is watched through a small synchronizer. The bus side gives it one-cycle strobes for four accesses: status read, data read, data write and control-register-1 write.

No flag can be cleared by a single access. A status read has to see the flag set first, which arms that flag. Only then does a later, flag-specific access clear it. The block outputs four things:
- a read-only status byte;
- an interrupt request;
- a hold that stops the shift engine from loading the data register;
- a fault strobe that tells the control register to drop its enable, master and pin-direction bits.

Top module: `spi_flag_ctrl`

## Requirements
- R1: The status byte carries the received-byte flag at bit 7, the collision flag at bit 6 and the mode-fault flag at bit 4. Bits 5 and 3..0 always read 0, and the whole byte is 0 after reset.
- R2: A `xfer_done` strobe sets the received-byte flag (bit 7) on the next clock edge.
- R3: `data_load_block` is high exactly while the received-byte flag is set.
- R4: The received-byte flag clears on the first data read or data write that follows a status read which saw the flag set. A data access with no such earlier status read leaves the flag set.
- R5: The collision flag (bit 6) sets on the edge after a data write made while `xfer_busy` is high. It clears like R4: a status read that saw it set, then a later data read or write.
- R6: `ss_pin_n` passes through SYNC_STAGES flip-flops (default 2) that reset to 1. In every cycle where `is_master`, `ss_fault_en` and a synchronized low pin are all true, `fault_clr_pulse` is high, and the mode-fault flag (bit 4) is set on the following edge.
- R7: The mode-fault flag clears only on a control-register-1 write that follows a status read which saw it set. Data reads and writes leave it set.
- R8: `irq` equals `irq_en` AND (bit 7 OR bit 4). The collision flag never raises `irq`.
- R9: When a set event and a completing access fall in the same cycle, the flag stays set. A set event also disarms the flag, so a new status read is needed before it can be cleared.
- R10: A status read in the same cycle as a completing access does not arm the flag for that access. The access must come in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_done | input | 1 | Byte-complete strobe from the shift engine |
| xfer_busy | input | 1 | High while a transfer is in progress |
| ss_pin_n | input | 1 | Slave-select pin level (asynchronous) |
| is_master | input | 1 | Control bit: device is a master |
| ss_fault_en | input | 1 | Control setting: slave-select is used as a fault input |
| irq_en | input | 1 | Interrupt enable |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| ctl1_wr | input | 1 | Control register 1 write strobe |
| status_byte | output | 8 | Status register read value |
| irq | output | 1 | Interrupt request |
| data_load_block | output | 1 | Blocks loading of a new received byte |
| fault_clr_pulse | output | 1 | Tells control storage to clear enable, master and pin-direction bits |

## Verification
The clearing sequences are driven directly in several forms:
- an access with no status read before it, which must leave the flag set;
- a status read followed by the access, which must clear it;
- a status read in the same cycle as the access;
- a set event that lands together with a completing access.

Each form separates a correct arming rule from one that is too eager or too lax. The mode-fault path is tried with the pin held low while the device is a master, and again while it is not, so that the synchronizer delay and the qualifying conditions are both tested. Seeded random strobes then mix every access against a cycle-level model, which catches wrong cross-links between flags and the wrong completing access for each flag.

// File: rtl/spi_flag_pkg.sv
// Shared constants for the SPI status flag controller.
// Assumes: the status byte layout is fixed, because software decodes these bit positions.
package spi_flag_pkg;
    localparam int STATUS_W  = 8;
    localparam int NUM_FLAGS = 3;
    // flag indices inside the controller
    localparam int FLG_RX    = 0;
    localparam int FLG_COL   = 1;
    localparam int FLG_FLT   = 2;
    // bit positions in the status byte
    localparam int POS_RX    = 7;
    localparam int POS_COL   = 6;
    localparam int POS_FLT   = 4;
endpackage

// File: rtl/spi_flag_cell.sv
// One status flag with its arming bit.
// Behaviour:
// - A set event always wins and also clears the arming bit.
// - A status read that samples the flag high arms it.
// - Once armed, the next completing access clears both the flag and the arming bit.
// Assumes: all inputs are single-cycle strobes synchronous to clk.
module spi_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd_stat,
    input  logic done_acc,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;

    // flag and arming state update; set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_ev) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (armed_q && done_acc) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_stat && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/spi_modf_detect.sv
// Mode-fault detector.
// Synchronizes the slave-select pin and flags a fault while the device is a
// master, the pin is used as a fault input, and the pin reads low.
// Assumes: SYNC_STAGES >= 1, and the synchronizer resets to the inactive (high) level.
module spi_modf_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_pin_n,
    input  logic is_master,
    input  logic ss_fault_en,
    output logic fault_o
);
    logic [SYNC_STAGES-1:0] chain_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // single-stage capture of the pin
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= ss_pin_n;
            end
        end else begin : g_many
            // multi-stage synchronizer shift
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], ss_pin_n};
            end
        end
    endgenerate

    // qualify the synchronized pin with the control settings
    always_comb begin
        fault_o = is_master && ss_fault_en && !chain_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/spi_flag_ctrl.sv
// SPI status flag controller (top).
// Holds the received-byte, collision and mode-fault flags and builds the
// status byte, interrupt request, load hold and fault strobe from them.
// Assumes: the bus and shift-engine strobes last one cycle; ss_pin_n is asynchronous.
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_done,
    input  logic                xfer_busy,
    input  logic                ss_pin_n,
    input  logic                is_master,
    input  logic                ss_fault_en,
    input  logic                irq_en,
    input  logic                stat_rd,
    input  logic                data_rd,
    input  logic                data_wr,
    input  logic                ctl1_wr,
    output logic [STATUS_W-1:0] status_byte,
    output logic                irq,
    output logic                data_load_block,
    output logic                fault_clr_pulse
);
    logic                 fault_now;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] done_vec;
    logic [NUM_FLAGS-1:0] flag_vec;

    spi_modf_detect #(.SYNC_STAGES(SYNC_STAGES)) modf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss_pin_n   (ss_pin_n),
        .is_master  (is_master),
        .ss_fault_en(ss_fault_en),
        .fault_o    (fault_now)
    );

    // per-flag set events and completing accesses
    always_comb begin
        set_vec            = '0;
        done_vec           = '0;
        set_vec[FLG_RX]    = xfer_done;
        done_vec[FLG_RX]   = data_rd || data_wr;
        set_vec[FLG_COL]   = data_wr && xfer_busy;
        done_vec[FLG_COL]  = data_rd || data_wr;
        set_vec[FLG_FLT]   = fault_now;
        done_vec[FLG_FLT]  = ctl1_wr;
    end

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            spi_flag_cell cell_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_ev  (set_vec[g]),
                .rd_stat (stat_rd),
                .done_acc(done_vec[g]),
                .flag_o  (flag_vec[g])
            );
        end
    endgenerate

    // status byte assembly and derived outputs
    always_comb begin
        status_byte          = '0;
        status_byte[POS_RX]  = flag_vec[FLG_RX];
        status_byte[POS_COL] = flag_vec[FLG_COL];
        status_byte[POS_FLT] = flag_vec[FLG_FLT];
        irq                  = irq_en && (flag_vec[FLG_RX] || flag_vec[FLG_FLT]);
        data_load_block      = flag_vec[FLG_RX];
        fault_clr_pulse      = fault_now;
    end
endmodule

// File: rtl/spi_flag_chk.sv
// Assertion checker for spi_flag_ctrl, attached by bind.
// Assumes: the default status byte layout (bits 7, 6 and 4).
module spi_flag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_done,
    input logic       xfer_busy,
    input logic       irq_en,
    input logic       data_rd,
    input logic       data_wr,
    input logic       ctl1_wr,
    input logic [7:0] status_byte,
    input logic       irq,
    input logic       data_load_block,
    input logic       fault_clr_pulse
);
    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[5] == 1'b0 && status_byte[3:0] == 4'b0);
    a_r2_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> status_byte[7]);
    a_r3_hold_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        data_load_block == status_byte[7]);
    a_r4_rx_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_byte[7]) |-> $past(data_rd || data_wr));
    a_r5_col_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && xfer_busy) |=> status_byte[6]);
    a_r6_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr_pulse |=> status_byte[4]);
    a_r7_flt_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_byte[4]) |-> $past(ctl1_wr));
    a_r8_irq_sources: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_en && (status_byte[7] || status_byte[4])));
endmodule

bind spi_flag_ctrl spi_flag_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .xfer_done      (xfer_done),
    .xfer_busy      (xfer_busy),
    .irq_en         (irq_en),
    .data_rd        (data_rd),
    .data_wr        (data_wr),
    .ctl1_wr        (ctl1_wr),
    .status_byte    (status_byte),
    .irq            (irq),
    .data_load_block(data_load_block),
    .fault_clr_pulse(fault_clr_pulse)
);

// File: tb/spi_flag_ctrl_tb_top.sv
// Bench for spi_flag_ctrl.
// Runs directed clear sequences, then seeded random strobes, and compares the
// outputs each cycle with a cycle-level model built from the requirements.
module spi_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_done = 0, xfer_busy = 0, ss_pin_n = 1, is_master = 0;
    logic       ss_fault_en = 0, irq_en = 0, stat_rd = 0, data_rd = 0;
    logic       data_wr = 0, ctl1_wr = 0;
    logic [7:0] status_byte;
    logic       irq, data_load_block, fault_clr_pulse;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    // model state
    bit       m_rx, m_col, m_flt, a_rx, a_col, a_flt;
    bit [1:0] m_sync;

    always #2 clk = ~clk;

    spi_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .xfer_busy(xfer_busy),
        .ss_pin_n(ss_pin_n), .is_master(is_master), .ss_fault_en(ss_fault_en),
        .irq_en(irq_en), .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
        .ctl1_wr(ctl1_wr), .status_byte(status_byte), .irq(irq),
        .data_load_block(data_load_block), .fault_clr_pulse(fault_clr_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_fault();
        return is_master && ss_fault_en && !m_sync[1];
    endfunction

    // next {flag, armed} of one flag
    function automatic bit [1:0] flag_next(bit f, bit a, bit s, bit rd, bit acc);
        if (s)            return 2'b10;
        else if (a && acc) return 2'b00;
        else              return {f, a | (rd & f)};
    endfunction

    task automatic model_reset();
        {m_rx, m_col, m_flt, a_rx, a_col, a_flt} = '0;
        m_sync = 2'b11;
    endtask

    task automatic check_outputs();
        chk("R2/R4/R9/R10 rx bit7", int'(status_byte[7]), int'(m_rx));
        chk("R5 col bit6", int'(status_byte[6]), int'(m_col));
        chk("R6/R7 flt bit4", int'(status_byte[4]), int'(m_flt));
        chk("R1 zero bits", int'({status_byte[5], status_byte[3:0]}), 0);
        chk("R8 irq", int'(irq), int'(irq_en && (m_rx || m_flt)));
        chk("R3 load hold", int'(data_load_block), int'(m_rx));
        chk("R6 fault strobe", int'(fault_clr_pulse), int'(model_fault()));
    endtask

    task automatic model_step();
        bit [1:0] r, c, f;
        r = flag_next(m_rx, a_rx, xfer_done, stat_rd, data_rd | data_wr);
        c = flag_next(m_col, a_col, data_wr & xfer_busy, stat_rd, data_rd | data_wr);
        f = flag_next(m_flt, a_flt, model_fault(), stat_rd, ctl1_wr);
        {m_rx, a_rx} = r;
        {m_col, a_col} = c;
        {m_flt, a_flt} = f;
        m_sync = {m_sync[0], ss_pin_n};
    endtask

    // one clock: check now-settled outputs, advance model, wait for next negedge
    task automatic cyc();
        #1;
        check_outputs();
        model_step();
        @(negedge clk);
    endtask

    task automatic strobes(bit xd, bit sr, bit dr, bit dw, bit cw);
        xfer_done = xd; stat_rd = sr; data_rd = dr; data_wr = dw; ctl1_wr = cw;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset status", int'(status_byte), 0);
        irq_en = 1;

        // R4: access without a prior status read does not clear
        strobes(1, 0, 0, 0, 0); cyc();
        strobes(0, 0, 1, 0, 0); cyc();
        strobes(0, 0, 0, 0, 0); cyc();
        chk("R4 still set after unarmed read", int'(status_byte[7]), 1);
        strobes(0, 1, 0, 0, 0); cyc();
        strobes(0, 0, 0, 1, 0); cyc();
        strobes(0, 0, 0, 0, 0); cyc();
        chk("R4 cleared after armed write", int'(status_byte[7]), 0);

        // R5 and R10: collision; status read together with the access does not clear
        xfer_busy = 1;
        strobes(0, 0, 0, 1, 0); cyc();
        xfer_busy = 0;
        strobes(0, 1, 1, 0, 0); cyc();
        strobes(0, 0, 0, 0, 0); cyc();
        chk("R10 col kept after same-cycle read", int'(status_byte[6]), 1);
        strobes(0, 0, 1, 0, 0); cyc();
        strobes(0, 0, 0, 0, 0); cyc();
        chk("R5 col cleared", int'(status_byte[6]), 0);

        // R9: set wins, and the set disarms the flag
        strobes(1, 0, 0, 0, 0); cyc();
        strobes(0, 1, 0, 0, 0); cyc();
        strobes(1, 0, 1, 0, 0); cyc();
        strobes(0, 0, 1, 0, 0); cyc();
        strobes(0, 0, 0, 0, 0); cyc();
        chk("R9 set wins and disarms", int'(status_byte[7]), 1);
        strobes(0, 1, 0, 0, 0); cyc();
        strobes(0, 0, 1, 0, 0); cyc();
        strobes(0, 0, 0, 0, 0); cyc();

        // R6: pin low while not a master gives no fault
        ss_fault_en = 1; ss_pin_n = 0;
        repeat (4) cyc();
        chk("R6 no fault when not master", int'(status_byte[4]), 0);
        // R6 and R7: fault as master, data access does not clear, control write does
        is_master = 1;
        repeat (3) cyc();
        chk("R6 fault flagged", int'(status_byte[4]), 1);
        is_master = 0; ss_pin_n = 1;
        repeat (3) cyc();
        strobes(0, 1, 0, 0, 0); cyc();
        strobes(0, 0, 1, 1, 0); cyc();
        strobes(0, 0, 0, 0, 0); cyc();
        chk("R7 data access keeps fault", int'(status_byte[4]), 1);
        strobes(0, 0, 0, 0, 1); cyc();
        strobes(0, 0, 0, 0, 0); cyc();
        chk("R7 fault cleared", int'(status_byte[4]), 0);

        // seeded random phase
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            xfer_done   = ($urandom % 8) == 0;
            xfer_busy   = ($urandom % 2) == 0;
            stat_rd     = ($urandom % 4) == 0;
            data_rd     = ($urandom % 6) == 0;
            data_wr     = ($urandom % 6) == 0;
            ctl1_wr     = ($urandom % 8) == 0;
            ss_pin_n    = ($urandom % 5) != 0;
            is_master   = ($urandom % 3) != 0;
            ss_fault_en = ($urandom % 2) == 0;
            irq_en      = ($urandom % 4) != 0;
            cyc();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule